// File: doc/BRIEF.md
# Mode-Aware Call/Return Stack

This block keeps the return addresses of a core whose instructions come either from its small local register memory or from the large shared main memory. A call strobe pushes one packed frame: the address after the calling instruction, the zero and carry flags, and a bit that records which memory the caller ran from. The block then steers the core to the call target and to the target's mode. A return strobe pops the newest frame and hands back the address, both flags and the mode. Because the mode travels with the frame, shared-memory code can call into local code and get back, and the reverse works too.

Each output is registered. The cycle after a strobe, the outputs give the program counter, flags and mode that the core should use next. In a cycle with no strobe, the outputs give the following sequential address and pass the live flags and mode through. Two sticky bits report pushes onto a full stack and pops from an empty one. Reset clears both bits.

Top module: `mode_return_stack`

## Requirements
- R1: While reset is low, and on the first sample after it, `pc_o`, `zero_o`, `carry_o`, `mode_o`, `ovf_o` and `udf_o` are all zero, and the stack holds no frames.
- R2: A call (`call_i` high) makes the next cycle's outputs `pc_o = tgt_pc_i` and `mode_o = tgt_mode_i`, with `zero_o`/`carry_o` taken from `zero_i`/`carry_i`. It also pushes the frame {mode_i, carry_i, zero_i, pc_i+1}.
- R3: A return (`ret_i` high, `call_i` low) on a non-empty stack pops the newest frame (last in, first out). The next cycle's `pc_o`, `zero_o`, `carry_o` and `mode_o` equal that frame's fields.
- R4: With neither strobe high, the next cycle gives `pc_o = pc_i + 1` (modulo 2^16), and `zero_o`, `carry_o`, `mode_o` follow `zero_i`, `carry_i`, `mode_i`.
- R5: A call while DEPTH frames are held discards the new frame and sets `ovf_o`, which stays high until reset. The jump to the target still takes place.
- R6: A return on an empty stack gives zero for `pc_o`, `zero_o`, `carry_o` and `mode_o`, and sets `udf_o`, which stays high until reset.
- R7: When `call_i` and `ret_i` are high in the same cycle, only the call acts. No frame is popped.
- R8: Mode 1 means shared-memory execution and mode 0 means local execution. A call made from either mode returns to that same mode, even after nested calls in the opposite mode.
- R9: The pushed return address wraps: a call at `pc_i = 16'hFFFF` later returns to `16'h0000`.
- R10: Reset applied in the middle of operation empties the stack and clears `ovf_o` and `udf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| tgt_pc_i | input | 16 | Call target address |
| tgt_mode_i | input | 1 | Mode at call target (1 = shared memory) |
| pc_i | input | 16 | Address of current instruction |
| zero_i | input | 1 | Current zero flag |
| carry_i | input | 1 | Current carry flag |
| mode_i | input | 1 | Current execution mode |
| pc_o | output | 16 | Next program counter |
| zero_o | output | 1 | Next zero flag |
| carry_o | output | 1 | Next carry flag |
| mode_o | output | 1 | Next execution mode |
| ovf_o | output | 1 | Sticky push-on-full flag |
| udf_o | output | 1 | Sticky pop-on-empty flag |

## Verification
The assertions assume that every input is a known value on each rising clock edge once reset is released, and that a strobe lasts exactly one cycle for each operation. From the strobes alone, the checker keeps its own count of how many frames are held. The bench drives new inputs one nanosecond after each edge, so inputs never change on an edge. It works through directed sequences that fill, overflow, drain and underflow the stack, crossing modes in both directions. It then issues a long run of random strobe mixes that includes simultaneous call and return, and it resets the block in the middle of the run.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
    localparam int PC_W = 16;

    // Frame layout: mode at the top bit, then carry, zero, then return address.
    typedef struct packed {
        logic            mode;
        logic            carry;
        logic            zero;
        logic [PC_W-1:0] pc;
    } frame_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            zero;
        logic            carry;
        logic            mode;
    } steer_t;
endpackage

// File: rtl/mrs_pointer.sv
module mrs_pointer #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             ovf,
    output logic             udf
);
    typedef struct packed {
        logic [PTR_W-1:0] level;
        logic             ovf;
        logic             udf;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    assign level = st_q.level;
    assign full  = (st_q.level == PTR_W'(DEPTH));
    assign empty = (st_q.level == '0);
    assign ovf   = st_q.ovf;
    assign udf   = st_q.udf;

    always_comb begin
        st_d = st_q;
        if (push_req) begin
            if (full) st_d.ovf   = 1'b1;
            else      st_d.level = st_q.level + PTR_W'(1);
        end else if (pop_req) begin
            if (empty) st_d.udf   = 1'b1;
            else       st_d.level = st_q.level - PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mrs_entry_store.sv
module mrs_entry_store
    import mrs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  frame_t           wr_frame,
    input  logic [IDX_W-1:0] rd_idx,
    output frame_t           rd_frame
);
    frame_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        frame_t slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) slot_d = wr_frame;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_frame = slot_q[rd_idx];
endmodule

// File: rtl/mode_return_stack.sv
module mode_return_stack
    import mrs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic [PC_W-1:0] tgt_pc_i,
    input  logic            tgt_mode_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            zero_i,
    input  logic            carry_i,
    input  logic            mode_i,
    output logic [PC_W-1:0] pc_o,
    output logic            zero_o,
    output logic            carry_o,
    output logic            mode_o,
    output logic            ovf_o,
    output logic            udf_o
);
    logic             do_push, do_pop;
    logic [PTR_W-1:0] level, level_m1;
    logic             full, empty;
    frame_t           push_frame, top_frame;
    steer_t           out_d, out_q;

    // Call takes priority over a return in the same cycle.
    assign do_push = call_i;
    assign do_pop  = ret_i & ~call_i;

    mrs_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (do_push),
        .pop_req  (do_pop),
        .level    (level),
        .full     (full),
        .empty    (empty),
        .ovf      (ovf_o),
        .udf      (udf_o)
    );

    assign level_m1 = level - PTR_W'(1);

    always_comb begin
        push_frame.mode  = mode_i;
        push_frame.carry = carry_i;
        push_frame.zero  = zero_i;
        push_frame.pc    = pc_i + PC_W'(1);
    end

    mrs_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_push & ~full),
        .wr_idx   (level[IDX_W-1:0]),
        .wr_frame (push_frame),
        .rd_idx   (level_m1[IDX_W-1:0]),
        .rd_frame (top_frame)
    );

    always_comb begin
        out_d = out_q;
        if (do_push) begin
            out_d.pc    = tgt_pc_i;
            out_d.mode  = tgt_mode_i;
            out_d.zero  = zero_i;
            out_d.carry = carry_i;
        end else if (do_pop) begin
            if (empty) begin
                out_d = '0;
            end else begin
                out_d.pc    = top_frame.pc;
                out_d.mode  = top_frame.mode;
                out_d.zero  = top_frame.zero;
                out_d.carry = top_frame.carry;
            end
        end else begin
            out_d.pc    = pc_i + PC_W'(1);
            out_d.mode  = mode_i;
            out_d.zero  = zero_i;
            out_d.carry = carry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pc_o    = out_q.pc;
    assign zero_o  = out_q.zero;
    assign carry_o = out_q.carry;
    assign mode_o  = out_q.mode;
endmodule

// File: rtl/mode_return_stack_chk.sv
module mode_return_stack_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        call_i,
    input logic        ret_i,
    input logic [15:0] tgt_pc_i,
    input logic        tgt_mode_i,
    input logic [15:0] pc_i,
    input logic [15:0] pc_o,
    input logic        zero_o,
    input logic        carry_o,
    input logic        mode_o,
    input logic        ovf_o,
    input logic        udf_o
);
    int held;

    always_ff @(posedge clk) begin
        if (!rst_n)                        held <= 0;
        else if (call_i && held < DEPTH)   held <= held + 1;
        else if (!call_i && ret_i && held > 0) held <= held - 1;
    end

    AST_CALL_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        call_i |=> (pc_o == $past(tgt_pc_i)) && (mode_o == $past(tgt_mode_i))); // R2

    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && !ret_i) |=> (pc_o == $past(pc_i) + 16'd1)); // R4

    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && held == DEPTH) |=> ovf_o); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R5

    AST_UDF_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && held == 0) |=> udf_o && pc_o == 16'd0 && !mode_o && !zero_o && !carry_o); // R6

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        udf_o |=> udf_o); // R6
endmodule

bind mode_return_stack mode_return_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .tgt_pc_i   (tgt_pc_i),
    .tgt_mode_i (tgt_mode_i),
    .pc_i       (pc_i),
    .pc_o       (pc_o),
    .zero_o     (zero_o),
    .carry_o    (carry_o),
    .mode_o     (mode_o),
    .ovf_o      (ovf_o),
    .udf_o      (udf_o)
);

// File: tb/test_mode_return_stack.sv
module test_mode_return_stack;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0;
    logic [15:0] tgt_pc_i = '0, pc_i = '0;
    logic        tgt_mode_i = 1'b0, zero_i = 1'b0, carry_i = 1'b0, mode_i = 1'b0;
    logic [15:0] pc_o;
    logic        zero_o, carry_o, mode_o, ovf_o, udf_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model: queue of frames {mode, carry, zero, pc}, sticky bits, expected outputs.
    logic [18:0] model_stk [$];
    logic        m_ovf = 1'b0, m_udf = 1'b0;
    logic [20:0] expv = '0; // {ovf, udf, mode, carry, zero, pc}

    always #2 clk = ~clk;

    mode_return_stack #(.DEPTH(DEPTH)) i_mode_return_stack (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .tgt_pc_i(tgt_pc_i), .tgt_mode_i(tgt_mode_i), .pc_i(pc_i),
        .zero_i(zero_i), .carry_i(carry_i), .mode_i(mode_i),
        .pc_o(pc_o), .zero_o(zero_o), .carry_o(carry_o), .mode_o(mode_o),
        .ovf_o(ovf_o), .udf_o(udf_o)
    );

    task automatic compare(input string req);
        logic [20:0] act;
        act = {ovf_o, udf_o, mode_o, carry_o, zero_o, pc_o};
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic step(input bit c, input bit r, input logic [15:0] tpc, input bit tm,
                        input logic [15:0] pc, input bit z, input bit cy, input bit m,
                        input string req);
        logic [18:0] fr;
        call_i = c; ret_i = r; tgt_pc_i = tpc; tgt_mode_i = tm;
        pc_i = pc; zero_i = z; carry_i = cy; mode_i = m;
        if (c) begin
            if (model_stk.size() < DEPTH) model_stk.push_back({m, cy, z, pc + 16'd1});
            else m_ovf = 1'b1;
            expv = {m_ovf, m_udf, tm, cy, z, tpc};
        end else if (r) begin
            if (model_stk.size() > 0) begin
                fr = model_stk.pop_back();
                expv = {m_ovf, m_udf, fr};
            end else begin
                m_udf = 1'b1;
                expv = {m_ovf, m_udf, 19'd0};
            end
        end else begin
            expv = {m_ovf, m_udf, m, cy, z, pc + 16'd1};
        end
        @(posedge clk); #1;
        compare(req);
    endtask

    task automatic do_reset(input string req);
        rst_n = 1'b0; call_i = 1'b0; ret_i = 1'b0;
        model_stk.delete(); m_ovf = 1'b0; m_udf = 1'b0; expv = '0;
        @(posedge clk); @(posedge clk); #1;
        compare(req);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset("R1");
        // R4: sequential flow, flags and mode pass through
        step(0, 0, 16'h0, 0, 16'h0100, 1, 0, 1, "R4");
        step(0, 0, 16'h0, 0, 16'hFFFF, 0, 1, 0, "R4");
        // R2 / R8: shared -> local -> shared calls
        step(1, 0, 16'h0040, 0, 16'h1234, 1, 0, 1, "R2");
        step(1, 0, 16'h8000, 1, 16'h0041, 0, 1, 0, "R8");
        step(0, 0, 16'h0, 0, 16'h8000, 1, 1, 1, "R4");
        // R3 / R8: unwind, mode restored each way
        step(0, 1, 16'h0, 0, 16'h8001, 0, 0, 1, "R3");
        step(0, 1, 16'h0, 0, 16'h0042, 0, 0, 0, "R8");
        // R6: pop on empty
        step(0, 1, 16'h0, 0, 16'h1235, 1, 1, 1, "R6");
        step(0, 0, 16'h0, 0, 16'h2000, 0, 0, 0, "R6");
        // R10: reset clears sticky bits
        do_reset("R10");
        // R5: fill then overflow
        for (int i = 0; i < DEPTH; i++) step(1, 0, 16'h0300 + 16'(i), i[0], 16'h0200 + 16'(i), i[1], i[2], ~i[0], "R2");
        step(1, 0, 16'h0777, 1, 16'h0666, 1, 1, 1, "R5");
        step(0, 0, 16'h0, 0, 16'h0050, 0, 0, 0, "R5");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 16'h0, 0, 16'h0, 0, 0, 0, "R3");
        step(0, 1, 16'h0, 0, 16'h0, 0, 0, 0, "R6");
        do_reset("R10");
        // R7: simultaneous call and return
        step(1, 0, 16'h0111, 0, 16'h0A00, 0, 0, 1, "R7");
        step(1, 1, 16'h0222, 1, 16'h0B00, 1, 0, 0, "R7");
        step(0, 1, 16'h0, 0, 16'h0, 0, 0, 0, "R7");
        step(0, 1, 16'h0, 0, 16'h0, 0, 0, 0, "R7");
        // R9: return address wraps
        step(1, 0, 16'h0010, 0, 16'hFFFF, 1, 1, 1, "R9");
        step(0, 1, 16'h0, 0, 16'h0010, 0, 0, 0, "R9");
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (i == 300) do_reset("R10");
            step(rv[0] & rv[1], rv[2] & rv[3] | (rv[0] & rv[1] & rv[4]), 16'($urandom), rv[5],
                 16'($urandom), rv[6], rv[7], rv[8], "R3");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule